// File: doc/BRIEF.md
# Record and Buffer Address Sequencer

This block drives the addressing side of an output stream engine that plays records out of a memory buffer. A buffer holds a programmed number of records, spaced a programmed stride apart in bytes. Each record-start event begins one record. If a header is attached, the block reads the header's two 32-bit words through a simple word-read request/response port. It then hands the engine a descriptor that gives where the sample data starts and how many samples it holds, and it counts the samples the engine reports as sent.

The sample count comes from a register in fixed-length mode. In variable-length mode it comes from the second header word. When a record completes, the next start address is the previous start address plus the stride. After the last record of the buffer, the block pulses buffer-done and goes back to the base address. Misuse is reported on plain status pins: a start event during a record (overrun, sticky), a header length outside the legal range (length error, sticky), and a stride too small for the record (configuration error, level).

The read request and the descriptor are valid/ready outputs. Once an output raises valid, it holds valid and keeps its address and length unchanged until ready is seen high at a clock edge. The read response is accepted only while `rd_rsp_ready` is high. The start event, the sample tick and all status pins are plain single-cycle or level signals.

Top module: `rec_addr_seq`

## Requirements
- R1: In fixed-length mode with no header (`var_len_en`=0, `hdr_en`=0), a start event issues no read request, and the descriptor gives address = record start address and length = `rec_size`.
- R2: When a header is present (`hdr_en`=1 or `var_len_en`=1), the block reads the word at the start address, then the word at start address + 4, and only then presents a descriptor whose address is start address + 8.
- R3: In variable-length mode the descriptor length equals the second header word, provided that word is in the range 2 to 2^24-1.
- R4: In variable-length mode, a second header word below 2 or above 2^24-1 is replaced by `rec_size`, and `len_err` goes high and stays high until reset.
- R5: After each completed record, the next record's start address is the previous start address plus `stride`. The first record after reset starts at `base_addr`.
- R6: `rec_done` pulses in the cycle of the Nth `smp_tick` after the descriptor is accepted, where N is the descriptor length, and not before.
- R7: Completion of record number `recs_per_buf` in a buffer pulses `buf_done` together with `rec_done`, and the following record starts again at `base_addr`.
- R8: A start event that arrives while a record is in progress creates no record and sets `overrun`, which stays high until reset.
- R9: `cfg_err` is high one cycle after `stride` is less than `rec_size` plus 8 (when a header is present) or less than `rec_size` (when none is present), and low otherwise.
- R10: Once raised, `rec_valid` and `rd_req_valid` stay high with stable address and length until the matching ready is high at a clock edge. The two are never high together.
- R11: After reset, no request or descriptor is valid and `overrun`, `len_err` and `cfg_err` are low for a legal configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Byte address of the first record of the buffer |
| rec_size | input | 24 | Samples per record in fixed-length mode |
| recs_per_buf | input | 24 | Records per buffer |
| stride | input | 32 | Byte distance between consecutive record starts |
| var_len_en | input | 1 | Take the length from the second header word |
| hdr_en | input | 1 | Records carry an 8-byte header |
| rec_start | input | 1 | Record-start event pulse |
| rd_req_valid | output | 1 | Header word read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Byte address of the header word |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Block waiting for a read response |
| rd_rsp_data | input | 32 | Read response word |
| rec_valid | output | 1 | Record descriptor valid |
| rec_ready | input | 1 | Descriptor accepted by the engine |
| rec_addr | output | 32 | Byte address of the first sample |
| rec_len | output | 24 | Samples in the record |
| smp_tick | input | 1 | One sample of the current record sent |
| rec_done | output | 1 | Last sample of the record sent |
| buf_done | output | 1 | Last record of the buffer completed |
| overrun | output | 1 | Sticky: start event during a record |
| len_err | output | 1 | Sticky: header length out of range |
| cfg_err | output | 1 | Stride too small for the record |

## Verification
On every cycle, the assertions check the handshake rules: held valid, stable address and length, and no overlap between request and descriptor. They also check that both error flags stay sticky, that buffer-done never appears without record-done, and that record-done only happens while a record is running. The correctness of the address arithmetic can only be shown by the bench's scenarios, which score descriptors and header-read addresses against an independent queue. The same holds for the stride chain across a buffer wrap, the header length selection and its clamping, the ignored start event and the exact tick that completes a record.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ0, S_RSP0, S_REQ1, S_RSP1, S_DESC, S_RUN
  } rseq_state_e;
endpackage

// File: rtl/rseq_len_sel.sv
// Chooses the record length: header word in variable mode, clamped to the
// register value when the header word is outside the legal range.
module rseq_len_sel #(
  parameter int DW = 32,
  parameter int LW = 24
) (
  input  logic          var_en,
  input  logic [DW-1:0] hdr_word,
  input  logic [LW-1:0] reg_len,
  output logic [LW-1:0] len,
  output logic          bad
);
  logic too_big;
  logic too_small;

  generate
    if (DW > LW) begin : g_wide
      assign too_big = |hdr_word[DW-1:LW];
    end else begin : g_narrow
      assign too_big = 1'b0;
    end
  endgenerate

  assign too_small = (hdr_word[LW-1:0] < LW'(2));
  assign bad       = var_en && (too_big || too_small);
  assign len       = (var_en && !bad) ? hdr_word[LW-1:0] : reg_len;
endmodule

// File: rtl/rseq_addr_gen.sv
// Tracks the record start offset from the base and the record index.
module rseq_addr_gen #(
  parameter int AW = 32,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [AW-1:0] stride,
  input  logic [LW-1:0] recs,
  output logic [AW-1:0] off,
  output logic          last_rec
);
  logic [LW-1:0] idx;

  assign last_rec = ({1'b0, idx} + (LW+1)'(1)) >= {1'b0, recs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off <= '0;
      idx <= '0;
    end else if (advance) begin
      if (last_rec) begin
        off <= '0;
        idx <= '0;
      end else begin
        off <= off + stride;
        idx <= idx + LW'(1);
      end
    end
  end
endmodule

// File: rtl/rseq_smp_ctr.sv
// Counts samples of the running record; flags the tick that ends it.
module rseq_smp_ctr #(
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [LW-1:0] len,
  output logic          last
);
  logic [LW-1:0] cnt;

  assign last = ({1'b0, cnt} + (LW+1)'(1)) >= {1'b0, len};

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + LW'(1);
  end
endmodule

// File: rtl/rec_addr_seq.sv
module rec_addr_seq
  import rseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] rec_size,
  input  logic [LW-1:0] recs_per_buf,
  input  logic [AW-1:0] stride,
  input  logic          var_len_en,
  input  logic          hdr_en,
  input  logic          rec_start,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [AW-1:0] rec_addr,
  output logic [LW-1:0] rec_len,
  input  logic          smp_tick,
  output logic          rec_done,
  output logic          buf_done,
  output logic          overrun,
  output logic          len_err,
  output logic          cfg_err
);
  localparam int HDR_BYTES = 8;
  localparam int WORD_BYTES = DW / 8;

  rseq_state_e   st, st_nxt;
  logic [LW-1:0] len_q;
  logic [AW-1:0] off;
  logic [AW-1:0] start_addr;
  logic          has_hdr;
  logic          last_rec;
  logic          smp_last;
  logic [LW-1:0] sel_len;
  logic          sel_bad;
  logic [AW:0]   need;

  assign has_hdr    = hdr_en || var_len_en;
  assign start_addr = base_addr + off;

  rseq_len_sel #(.DW(DW), .LW(LW)) u_len (
    .var_en   (var_len_en),
    .hdr_word (rd_rsp_data),
    .reg_len  (rec_size),
    .len      (sel_len),
    .bad      (sel_bad)
  );

  rseq_addr_gen #(.AW(AW), .LW(LW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (rec_done),
    .stride   (stride),
    .recs     (recs_per_buf),
    .off      (off),
    .last_rec (last_rec)
  );

  rseq_smp_ctr #(.LW(LW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (rec_valid && rec_ready),
    .tick  (st == S_RUN && smp_tick),
    .len   (len_q),
    .last  (smp_last)
  );

  assign rd_req_valid = (st == S_REQ0) || (st == S_REQ1);
  assign rd_req_addr  = start_addr + ((st == S_REQ1) ? AW'(WORD_BYTES) : '0);
  assign rd_rsp_ready = (st == S_RSP0) || (st == S_RSP1);
  assign rec_valid    = (st == S_DESC);
  assign rec_addr     = start_addr + (has_hdr ? AW'(HDR_BYTES) : '0);
  assign rec_len      = len_q;
  assign rec_done     = (st == S_RUN) && smp_tick && smp_last;
  assign buf_done     = rec_done && last_rec;

  always_comb begin
    st_nxt = st;
    case (st)
      S_IDLE: if (rec_start) st_nxt = has_hdr ? S_REQ0 : S_DESC;
      S_REQ0: if (rd_req_ready) st_nxt = S_RSP0;
      S_RSP0: if (rd_rsp_valid) st_nxt = S_REQ1;
      S_REQ1: if (rd_req_ready) st_nxt = S_RSP1;
      S_RSP1: if (rd_rsp_valid) st_nxt = S_DESC;
      S_DESC: if (rec_ready) st_nxt = S_RUN;
      S_RUN:  if (rec_done) st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  always_comb begin
    need = {{(AW+1-LW){1'b0}}, rec_size};
    if (has_hdr) need = need + (AW+1)'(HDR_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      len_q   <= '0;
      overrun <= 1'b0;
      len_err <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      st      <= st_nxt;
      cfg_err <= ({1'b0, stride} < need);
      if (st == S_IDLE && rec_start) len_q <= rec_size;
      if (st != S_IDLE && rec_start) overrun <= 1'b1;
      if (st == S_RSP1 && rd_rsp_valid) begin
        len_q <= sel_len;
        if (sel_bad) len_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rec_addr_seq_chk.sv
module rec_addr_seq_chk #(
  parameter int AW = 32,
  parameter int LW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [AW-1:0] rec_addr,
  input logic [LW-1:0] rec_len,
  input logic          smp_tick,
  input logic          rec_done,
  input logic          buf_done,
  input logic          overrun,
  input logic          len_err
);
  // R10
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_addr) && $stable(rec_len));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rec_valid));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R4
  len_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

  // R7
  buf_with_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> rec_done);

  // R6
  done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> smp_tick && !rec_valid && !rd_req_valid);
endmodule

bind rec_addr_seq rec_addr_seq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rec_valid    (rec_valid),
  .rec_ready    (rec_ready),
  .rec_addr     (rec_addr),
  .rec_len      (rec_len),
  .smp_tick     (smp_tick),
  .rec_done     (rec_done),
  .buf_done     (buf_done),
  .overrun      (overrun),
  .len_err      (len_err)
);

// File: tb/rec_addr_seq_test.sv
`timescale 1ns/1ps
module rec_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] base_addr, stride;
  logic [23:0] rec_size, recs_per_buf;
  logic        var_len_en, hdr_en, rec_start;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        rec_valid, rec_ready;
  logic [31:0] rec_addr;
  logic [23:0] rec_len;
  logic        smp_tick, rec_done, buf_done, overrun, len_err, cfg_err;

  int n_chk = 0, n_fail = 0;
  int desc_cnt = 0, done_cnt = 0, bdone_cnt = 0, rd_cnt = 0;
  logic [31:0] exp_addr[$], exp_req[$];
  logic [23:0] exp_len[$];
  logic [31:0] hdr_word;
  bit finished = 0;

  always #4 clk = ~clk;

  rec_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .rec_size(rec_size),
    .recs_per_buf(recs_per_buf), .stride(stride), .var_len_en(var_len_en),
    .hdr_en(hdr_en), .rec_start(rec_start), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_addr(rec_addr), .rec_len(rec_len), .smp_tick(smp_tick),
    .rec_done(rec_done), .buf_done(buf_done), .overrun(overrun),
    .len_err(len_err), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: descriptors scored against the expected queue
  always @(negedge clk) begin
    if (rst_n && rec_valid && rec_ready) begin
      desc_cnt++;
      if (exp_addr.size() == 0) check(0, "R1/R2 unexpected descriptor", rec_addr, 0);
      else begin
        logic [31:0] ea;
        logic [23:0] el;
        ea = exp_addr.pop_front();
        el = exp_len.pop_front();
        check(rec_addr == ea, "R5 descriptor address", rec_addr, ea);
        check(rec_len == el, "R3 descriptor length", {8'h0, rec_len}, {8'h0, el});
      end
    end
    if (rst_n && rec_done) done_cnt++;
    if (rst_n && buf_done) bdone_cnt++;
  end

  // Header memory responder with request address scoring
  initial begin
    rd_rsp_valid = 0;
    rd_rsp_data  = 0;
    forever begin
      @(negedge clk);
      if (rst_n && rd_req_valid && rd_req_ready) begin
        logic [31:0] a;
        a = rd_req_addr;
        rd_cnt++;
        if (exp_req.size() == 0) check(0, "R2 unexpected read", a, 0);
        else begin
          logic [31:0] e;
          e = exp_req.pop_front();
          check(a == e, "R2 read address", a, e);
        end
        @(posedge clk); #1;
        rd_rsp_valid = 1;
        rd_rsp_data  = a[2] ? hdr_word : 32'h0BAD_F00D;
        @(posedge clk); #1;
        rd_rsp_valid = 0;
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // Driver: pushes expectations, starts one record and feeds its samples
  task automatic run_record(input logic [31:0] start, input logic [23:0] len,
                            input bit hdr, input bit stall, input bit poke,
                            input bit last);
    int d0, r0, b0;
    logic [31:0] data_addr;
    data_addr = start + (hdr ? 32'd8 : 32'd0);
    exp_addr.push_back(data_addr);
    exp_len.push_back(len);
    if (hdr) begin
      exp_req.push_back(start);
      exp_req.push_back(start + 32'd4);
    end
    d0 = desc_cnt; r0 = done_cnt; b0 = bdone_cnt;
    if (stall) rec_ready = 0;
    @(posedge clk); #1 rec_start = 1;
    @(posedge clk); #1 rec_start = 0;
    if (stall) begin
      repeat (hdr ? 8 : 3) @(posedge clk);
      @(negedge clk);
      check(rec_valid === 1'b1, "R10 valid held", {31'h0, rec_valid}, 1);
      check(rec_addr == data_addr, "R10 address held", rec_addr, data_addr);
      @(posedge clk); #1 rec_ready = 1;
    end
    while (desc_cnt == d0 && !finished) @(negedge clk);
    @(posedge clk); #1;
    if (poke) begin
      rec_start = 1;
      @(posedge clk); #1 rec_start = 0;
      check(overrun === 1'b1, "R8 overrun set", {31'h0, overrun}, 1);
    end
    for (int k = 0; k < int'(len); k++) begin
      smp_tick = 1;
      if (k == int'(len) - 1)
        check(done_cnt == r0, "R6 no early done", done_cnt, r0);
      @(posedge clk); #1;
    end
    smp_tick = 0;
    check(done_cnt == r0 + 1, "R6 done after N ticks", done_cnt, r0 + 1);
    check(bdone_cnt == b0 + (last ? 1 : 0), "R7 buffer done", bdone_cnt,
          b0 + (last ? 1 : 0));
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rec_start = 0; smp_tick = 0; rec_ready = 1; rd_req_ready = 1;
    base_addr = 32'h1000; rec_size = 24'd4; recs_per_buf = 24'd3;
    stride = 32'h10; var_len_en = 0; hdr_en = 0; hdr_word = 0;
    do_reset();
    @(negedge clk);
    // R11 reset state
    check(!rec_valid && !rd_req_valid, "R11 nothing valid", {rec_valid, rd_req_valid}, 0);
    check(!overrun && !len_err && !cfg_err, "R11 flags low",
          {overrun, len_err, cfg_err}, 0);

    // Fixed length, no header: R1, R5, R7, R10
    run_record(32'h1000, 24'd4, 0, 0, 0, 0);
    run_record(32'h1010, 24'd4, 0, 1, 0, 0);
    run_record(32'h1020, 24'd4, 0, 0, 0, 1);
    run_record(32'h1000, 24'd4, 0, 0, 1, 0);   // R7 reload; R8 poke
    run_record(32'h1010, 24'd4, 0, 0, 0, 0);   // R8 ignored start made no record
    check(rd_cnt == 0, "R1 no header reads", rd_cnt, 0);
    check(overrun === 1'b1, "R8 overrun sticky", {31'h0, overrun}, 1);

    // Header present, fixed length: R2
    base_addr = 32'h2000; rec_size = 24'd3; recs_per_buf = 24'd2;
    stride = 32'h20; hdr_en = 1;
    do_reset();
    check(overrun === 1'b0, "R11 overrun cleared", {31'h0, overrun}, 0);
    hdr_word = 32'd9;   // ignored in fixed-length mode
    run_record(32'h2000, 24'd3, 1, 0, 0, 0);
    run_record(32'h2020, 24'd3, 1, 1, 0, 1);
    check(rd_cnt == 4, "R2 two reads per record", rd_cnt, 4);

    // Variable length: R3, R4
    base_addr = 32'h3000; rec_size = 24'd4; recs_per_buf = 24'd4;
    stride = 32'h40; hdr_en = 0; var_len_en = 1;
    do_reset();
    hdr_word = 32'd5;
    run_record(32'h3000, 24'd5, 1, 0, 0, 0);
    check(len_err === 1'b0, "R3 legal length no error", {31'h0, len_err}, 0);
    hdr_word = 32'h0100_0000;
    run_record(32'h3040, 24'd4, 1, 0, 0, 0);
    check(len_err === 1'b1, "R4 oversize clamps", {31'h0, len_err}, 1);
    hdr_word = 32'd1;
    run_record(32'h3080, 24'd4, 1, 0, 0, 0);
    check(len_err === 1'b1, "R4 sticky after undersize", {31'h0, len_err}, 1);

    // Configuration check: R9
    var_len_en = 0; hdr_en = 1; rec_size = 24'd4; stride = 32'd8;
    @(posedge clk); #1; @(negedge clk);
    check(cfg_err === 1'b1, "R9 stride below size+8", {31'h0, cfg_err}, 1);
    stride = 32'd12;
    @(posedge clk); #1; @(negedge clk);
    check(cfg_err === 1'b0, "R9 stride equal size+8", {31'h0, cfg_err}, 0);
    hdr_en = 0; stride = 32'd3;
    @(posedge clk); #1; @(negedge clk);
    check(cfg_err === 1'b1, "R9 stride below size", {31'h0, cfg_err}, 1);
    stride = 32'd4;
    @(posedge clk); #1; @(negedge clk);
    check(cfg_err === 1'b0, "R9 stride equal size", {31'h0, cfg_err}, 0);

    check(exp_addr.size() == 0 && exp_req.size() == 0, "R2 all expected items seen",
          exp_addr.size() + exp_req.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule